// File: doc/BRIEF.md
# Byte-Serial Audio Sample Sequencer

This block lets a host move audio samples through a single 8-bit data port, one byte at a time. A small register interface with a 2-bit address shares one location, the data address, between two directions. A host write to that address feeds a playback holding register. A host read from it drains a capture holding register.

Each direction has its own byte pointer, and the pointer moves forward by one on every accepted access. It stops at the last byte of the sample. The capture side then keeps returning that last byte, and the playback side drops any further bytes. A pointer starts again only when its converter takes part in a sample event:

- An ADC-side strobe loads a fresh capture word and points the capture side back at its first byte.
- A DAC-side strobe hands the assembled playback word out on a parallel bus with a one-cycle valid pulse and clears the playback side.

The sample length is 1, 2 or 4 bytes, chosen by a mono/stereo input and an 8/16-bit input. Bytes move left channel before right channel, and high byte before low byte. A parallel sample word is therefore laid out in transfer order, most significant byte first.

While an initialization input is high, the port is inert:
- Data writes are refused.
- Data reads return the fixed value 0x80.
- Neither pointer moves.

Top module: `pio_sample_sequencer`

## Requirements
- R1: Only accesses to address 3 reach the sample path. A write there goes to playback and a read there returns capture data. A read at any other address returns 0x00, and accesses at other addresses change neither pointer nor any holding register.
- R2: The sample length is 1 byte (mono, 8-bit), 2 bytes (stereo 8-bit or mono 16-bit) or 4 bytes (stereo 16-bit). Transfer byte k is bits [31-8k:24-8k] of a 32-bit sample word, so byte 0 is bits 31:24.
- R3: A data read returns, one cycle later on `host_rdata`, the capture byte at the current pointer and moves the pointer forward by one. `cap_next_idx` always shows the index of the byte the next read will return.
- R4: Once the capture pointer reaches the last byte of the sample, further reads return that last byte and the pointer stays there.
- R5: An `adc_stb` pulse loads `adc_word` into the capture register and sets `cap_next_idx` to 0 on the next cycle.
- R6: If `adc_stb` and a data read occur in the same cycle, the read returns the byte of the old sample at the old pointer, and the pointer goes to 0 for the new sample.
- R7: Each accepted data write places `host_wdata` at transfer byte position k of the playback word, where k is the playback pointer, and then moves the pointer forward.
- R8: When the last byte of a sample has been written, `play_full` rises. While it is high, data writes are dropped.
- R9: A `dac_stb` pulse puts the playback word on `dac_word`, with unwritten bytes reading as zero, and raises `dac_valid` for exactly one cycle. It also clears the holding register, the pointer and `play_full`. A data write in the same cycle as `dac_stb` is dropped.
- R10: While `init_i` is high, data reads return 0x80, data writes are dropped, and neither pointer moves.
- R11: After a synchronous reset, `host_rdata`, `dac_word`, `cap_next_idx`, `play_full` and `dac_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_i | input | 1 | Initialization in progress; data port inert |
| host_addr | input | 2 | Host register address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| fmt_stereo | input | 1 | 1 = two channels |
| fmt_16bit | input | 1 | 1 = 16-bit samples |
| adc_stb | input | 1 | New capture sample present |
| adc_word | input | 32 | Capture sample, transfer order MSB first |
| dac_stb | input | 1 | DAC takes the playback sample |
| dac_word | output | 32 | Assembled playback sample |
| dac_valid | output | 1 | One-cycle pulse with `dac_word` |
| cap_next_idx | output | 2 | Index of the next capture byte to be read |
| play_full | output | 1 | All playback bytes of the sample written |

## Verification
Several behaviours are checked by the assertions on every cycle:
- The capture pointer returns to zero after `adc_stb`.
- The capture pointer holds at the last byte.
- While `init_i` is high, reads return 0x80 and neither pointer moves.
- The playback word freezes while `play_full` is high.
- The single-cycle `dac_valid` pulse and the playback re-arm follow `dac_stb`.
- Reads at non-data addresses return zero.

Other behaviours can only be shown by the bench's scenarios:
- The byte order for each of the four formats.
- The exact assembled words.
- That a write made during initialization, or at the same time as `dac_stb`, never appears in a later `dac_word`.
- The old-data result of a read that collides with a capture load.

// File: rtl/pio_seq_pkg.sv
package pio_seq_pkg;

  // Index of the last transfer byte for a format: 1, 2 or 4 bytes per sample.
  function automatic logic [1:0] last_byte_idx(input logic stereo, input logic wide);
    case ({stereo, wide})
      2'b00:   last_byte_idx = 2'd0;
      2'b01,
      2'b10:   last_byte_idx = 2'd1;
      default: last_byte_idx = 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/pio_cap_track.sv
module pio_cap_track #(
  parameter int          BYTE_W    = 8,
  parameter int          NBYTES    = 4,
  parameter logic [7:0]  INIT_BYTE = 8'h80,
  localparam int         PTR_W     = $clog2(NBYTES),
  localparam int         WORD_W    = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              rd_any,
  input  logic              rd_hit,
  input  logic              adc_stb,
  input  logic [WORD_W-1:0] adc_word,
  input  logic [PTR_W-1:0]  last,
  output logic [BYTE_W-1:0] rd_byte,
  output logic [PTR_W-1:0]  ptr
);

  logic [WORD_W-1:0] cap_word;
  logic [BYTE_W-1:0] lane [NBYTES];

  // Transfer byte g sits at the g-th byte from the top of the word.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane[g] = cap_word[WORD_W-1-g*BYTE_W -: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_word <= '0;
      ptr      <= '0;
      rd_byte  <= '0;
    end else begin
      if (rd_any) begin
        if (!rd_hit)     rd_byte <= '0;
        else if (init_i) rd_byte <= BYTE_W'(INIT_BYTE);
        else             rd_byte <= lane[ptr];
      end
      if (adc_stb) begin
        cap_word <= adc_word;
        ptr      <= '0;
      end else if (rd_hit && !init_i && ptr < last) begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  p_rearm_r5: assert property (@(posedge clk) disable iff (rst)
    adc_stb |=> (ptr == '0));

  p_hold_last_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && !adc_stb && ptr >= last) |=> $stable(ptr));

  p_init_read_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && init_i) |=> (rd_byte == BYTE_W'(INIT_BYTE)));

  p_init_ptr_r10: assert property (@(posedge clk) disable iff (rst)
    (init_i && !adc_stb) |=> $stable(ptr));

endmodule

// File: rtl/pio_play_track.sv
module pio_play_track #(
  parameter int  BYTE_W = 8,
  parameter int  NBYTES = 4,
  localparam int PTR_W  = $clog2(NBYTES),
  localparam int WORD_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              wr_hit,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              dac_stb,
  input  logic [PTR_W-1:0]  last,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_valid,
  output logic [PTR_W-1:0]  ptr,
  output logic              full
);

  logic              accept;
  logic [WORD_W-1:0] hold_word;

  assign accept = wr_hit && !init_i && !full && !dac_stb;

  // One holding lane per transfer byte, written when the pointer selects it.
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst || dac_stb)                     lane_q <= '0;
      else if (accept && ptr == PTR_W'(g))    lane_q <= wdata;
    end
    assign hold_word[WORD_W-1-g*BYTE_W -: BYTE_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_word  <= '0;
      dac_valid <= 1'b0;
      ptr       <= '0;
      full      <= 1'b0;
    end else begin
      dac_valid <= dac_stb;
      if (dac_stb) begin
        dac_word <= hold_word;
        ptr      <= '0;
        full     <= 1'b0;
      end else if (accept) begin
        if (ptr >= last) full <= 1'b1;
        else             ptr  <= ptr + 1'b1;
      end
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    dac_stb |=> dac_valid);

  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !dac_stb |=> !dac_valid);

  p_rearm_r9: assert property (@(posedge clk) disable iff (rst)
    dac_stb |=> (ptr == '0 && !full));

  p_drop_full_r8: assert property (@(posedge clk) disable iff (rst)
    (full && !dac_stb) |=> ($stable(hold_word) && full));

  p_init_block_r10: assert property (@(posedge clk) disable iff (rst)
    (init_i && !dac_stb) |=> ($stable(hold_word) && $stable(ptr)));

endmodule

// File: rtl/pio_sample_sequencer.sv
module pio_sample_sequencer #(
  parameter int         BYTE_W    = 8,
  parameter int         NBYTES    = 4,
  parameter int         ADDR_W    = 2,
  parameter int         DATA_ADDR = 3,
  parameter logic [7:0] INIT_BYTE = 8'h80,
  localparam int        PTR_W     = $clog2(NBYTES),
  localparam int        WORD_W    = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              fmt_stereo,
  input  logic              fmt_16bit,
  input  logic              adc_stb,
  input  logic [WORD_W-1:0] adc_word,
  input  logic              dac_stb,
  output logic [WORD_W-1:0] dac_word,
  output logic              dac_valid,
  output logic [PTR_W-1:0]  cap_next_idx,
  output logic              play_full
);
  import pio_seq_pkg::*;

  logic             addr_hit;
  logic [PTR_W-1:0] last;

  assign addr_hit = (host_addr == ADDR_W'(DATA_ADDR));
  assign last     = PTR_W'(last_byte_idx(fmt_stereo, fmt_16bit));

  pio_cap_track #(
    .BYTE_W(BYTE_W), .NBYTES(NBYTES), .INIT_BYTE(INIT_BYTE)
  ) u_cap (
    .clk     (clk),
    .rst     (rst),
    .init_i  (init_i),
    .rd_any  (host_rd),
    .rd_hit  (host_rd && addr_hit),
    .adc_stb (adc_stb),
    .adc_word(adc_word),
    .last    (last),
    .rd_byte (host_rdata),
    .ptr     (cap_next_idx)
  );

  pio_play_track #(
    .BYTE_W(BYTE_W), .NBYTES(NBYTES)
  ) u_play (
    .clk      (clk),
    .rst      (rst),
    .init_i   (init_i),
    .wr_hit   (host_wr && addr_hit),
    .wdata    (host_wdata),
    .dac_stb  (dac_stb),
    .last     (last),
    .dac_word (dac_word),
    .dac_valid(dac_valid),
    .ptr      (),
    .full     (play_full)
  );

  p_other_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !addr_hit) |=> (host_rdata == '0));

endmodule

// File: tb/pio_sample_sequencer_bench.sv
`timescale 1ns/1ps
module pio_sample_sequencer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        init_i = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        fmt_stereo = 1'b1;
  logic        fmt_16bit = 1'b1;
  logic        adc_stb = 1'b0;
  logic [31:0] adc_word = 32'h0;
  logic        dac_stb = 1'b0;
  logic [31:0] dac_word;
  logic        dac_valid;
  logic [1:0]  cap_next_idx;
  logic        play_full;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  pio_sample_sequencer u_pio_sample_sequencer (
    .clk(clk), .rst(rst), .init_i(init_i), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .fmt_stereo(fmt_stereo), .fmt_16bit(fmt_16bit),
    .adc_stb(adc_stb), .adc_word(adc_word), .dac_stb(dac_stb),
    .dac_word(dac_word), .dac_valid(dac_valid),
    .cap_next_idx(cap_next_idx), .play_full(play_full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_fmt(input logic st, input logic w);
    fmt_stereo = st; fmt_16bit = w;
  endtask

  task automatic rd_data(output logic [7:0] v);
    host_addr = 2'd3; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
  endtask

  task automatic wr_data(input logic [7:0] b);
    host_addr = 2'd3; host_wr = 1'b1; host_wdata = b;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic load_adc(input logic [31:0] w);
    adc_stb = 1'b1; adc_word = w;
    @(negedge clk);
    adc_stb = 1'b0;
  endtask

  task automatic fire_dac(input string req, input logic [31:0] exp);
    dac_stb = 1'b1;
    @(negedge clk);
    dac_stb = 1'b0;
    chk({req, " dac_valid high"}, 32'(dac_valid), 32'd1);
    chk({req, " dac_word"}, dac_word, exp);
    chk({req, " play_full cleared"}, 32'(play_full), 32'd0);
    @(negedge clk);
    chk({req, " dac_valid one cycle"}, 32'(dac_valid), 32'd0);
  endtask

  task automatic t_reset;
    chk("R11 host_rdata", 32'(host_rdata), 32'h0);
    chk("R11 dac_word", dac_word, 32'h0);
    chk("R11 cap_next_idx", 32'(cap_next_idx), 32'd0);
    chk("R11 play_full", 32'(play_full), 32'd0);
    chk("R11 dac_valid", 32'(dac_valid), 32'd0);
  endtask

  task automatic t_cap_stereo16;
    logic [7:0] v;
    set_fmt(1'b1, 1'b1);
    load_adc(32'hA1B2C3D4);
    chk("R5 index after load", 32'(cap_next_idx), 32'd0);
    rd_data(v); chk("R3 byte0", 32'(v), 32'hA1); chk("R3 idx1", 32'(cap_next_idx), 32'd1);
    rd_data(v); chk("R2 byte1", 32'(v), 32'hB2); chk("R3 idx2", 32'(cap_next_idx), 32'd2);
    rd_data(v); chk("R2 byte2", 32'(v), 32'hC3); chk("R3 idx3", 32'(cap_next_idx), 32'd3);
    rd_data(v); chk("R2 byte3", 32'(v), 32'hD4); chk("R4 idx stays", 32'(cap_next_idx), 32'd3);
    rd_data(v); chk("R4 repeat last", 32'(v), 32'hD4); chk("R4 idx held", 32'(cap_next_idx), 32'd3);
  endtask

  task automatic t_cap_short;
    logic [7:0] v;
    set_fmt(1'b0, 1'b0);
    load_adc(32'h5E6F7081);
    rd_data(v); chk("R2 mono8 byte", 32'(v), 32'h5E); chk("R4 mono8 idx", 32'(cap_next_idx), 32'd0);
    rd_data(v); chk("R4 mono8 repeat", 32'(v), 32'h5E);
    set_fmt(1'b0, 1'b1);
    load_adc(32'h1234ABCD);
    rd_data(v); chk("R2 mono16 hi", 32'(v), 32'h12);
    rd_data(v); chk("R2 mono16 lo", 32'(v), 32'h34); chk("R4 mono16 idx", 32'(cap_next_idx), 32'd1);
    rd_data(v); chk("R4 mono16 repeat", 32'(v), 32'h34);
    set_fmt(1'b1, 1'b0);
    load_adc(32'h9A8B7C6D);
    rd_data(v); chk("R2 st8 left", 32'(v), 32'h9A);
    rd_data(v); chk("R2 st8 right", 32'(v), 32'h8B);
    rd_data(v); chk("R4 st8 repeat", 32'(v), 32'h8B);
  endtask

  task automatic t_collision;
    logic [7:0] v;
    set_fmt(1'b1, 1'b1);
    load_adc(32'h11223344);
    rd_data(v);
    host_addr = 2'd3; host_rd = 1'b1; adc_stb = 1'b1; adc_word = 32'h55667788;
    @(negedge clk);
    host_rd = 1'b0; adc_stb = 1'b0;
    chk("R6 old byte returned", 32'(host_rdata), 32'h22);
    chk("R6 index to zero", 32'(cap_next_idx), 32'd0);
    rd_data(v); chk("R6 new sample byte0", 32'(v), 32'h55);
  endtask

  task automatic t_play;
    set_fmt(1'b1, 1'b1);
    wr_data(8'hDE); wr_data(8'hAD);
    chk("R8 not full mid", 32'(play_full), 32'd0);
    wr_data(8'hBE); wr_data(8'hEF);
    chk("R8 full after last", 32'(play_full), 32'd1);
    wr_data(8'hFF);
    fire_dac("R7 stereo16", 32'hDEADBEEF);
    set_fmt(1'b1, 1'b0);
    wr_data(8'h4C); wr_data(8'h5D);
    chk("R8 st8 full", 32'(play_full), 32'd1);
    wr_data(8'h77);
    fire_dac("R2 st8 play", 32'h4C5D0000);
    set_fmt(1'b0, 1'b1);
    wr_data(8'hA5);
    fire_dac("R9 partial", 32'hA5000000);
    wr_data(8'h3B); wr_data(8'h6E);
    fire_dac("R9 pointer re-armed", 32'h3B6E0000);
  endtask

  task automatic t_dac_collision;
    set_fmt(1'b0, 1'b0);
    host_addr = 2'd3; host_wr = 1'b1; host_wdata = 8'h99; dac_stb = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; dac_stb = 1'b0;
    chk("R9 collision full", 32'(play_full), 32'd0);
    @(negedge clk);
    fire_dac("R9 collided write dropped", 32'h00000000);
  endtask

  task automatic t_init;
    logic [7:0] v;
    set_fmt(1'b1, 1'b1);
    load_adc(32'hCAFEF00D);
    rd_data(v);
    init_i = 1'b1;
    rd_data(v);
    chk("R10 init read value", 32'(v), 32'h80);
    chk("R10 init index held", 32'(cap_next_idx), 32'd1);
    set_fmt(1'b0, 1'b0);
    wr_data(8'hEE);
    chk("R10 init write blocked", 32'(play_full), 32'd0);
    init_i = 1'b0;
    rd_data(v);
    chk("R10 resume capture", 32'(v), 32'hFE);
    wr_data(8'h3C);
    fire_dac("R10 init write absent", 32'h3C000000);
  endtask

  task automatic t_other_addr;
    logic [1:0] idx0;
    set_fmt(1'b0, 1'b1);
    idx0 = cap_next_idx;
    host_addr = 2'd1; host_wr = 1'b1; host_wdata = 8'h99;
    @(negedge clk);
    host_wr = 1'b0;
    host_addr = 2'd0; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    chk("R1 other read zero", 32'(host_rdata), 32'h0);
    chk("R1 capture index untouched", 32'(cap_next_idx), 32'(idx0));
    chk("R1 playback untouched", 32'(play_full), 32'd0);
    wr_data(8'h21); wr_data(8'h43);
    fire_dac("R1 only data address", 32'h21430000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_cap_stereo16();
    t_cap_short();
    t_collision();
    t_play();
    t_dac_collision();
    t_init();
    t_other_addr();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule